// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming frames into a circular ring of receive buffer descriptors kept in a small local memory. Each descriptor has three parts: a status word, a length and a buffer pointer. Software fills in the pointer and sets the empty flag, which hands the descriptor to the hardware. When a frame arrives on the byte stream, the engine writes its bytes through a buffer-write port, starting at that pointer. At the last byte it writes back the length and the status, clears the empty flag, and moves to the next descriptor. After a descriptor marked with the wrap flag, it goes back to the ring base instead.

A frame may begin when the current descriptor is still owned by software. In that case the engine raises a busy event and enters a sticky halt. While halted it discards whole frames and counts each one. Software resumes reception with a clear-halt write to the receive status register. Events are write-one-to-clear. The interrupt output is the OR of the events that the mask enables.

Top module: `rx_ring_engine`

Register map (word address on `regAddr`):

| Address | Register | Contents |
|---|---|---|
| 0x00 | control | bit0 enable |
| 0x01 | ring base | base descriptor index |
| 0x02 | events | bit0 frame stored, bit1 busy; write-one-to-clear |
| 0x03 | mask | same bit positions as the events register |
| 0x04 | receive status | bit0 halted (writing 1 clears it); current descriptor index from bit 8 |
| 0x05 | drop counter | read-only |
| 0x80 \| idx<<2 \| f | descriptor `idx` | f=0 status, f=1 length, f=2 buffer pointer |

Descriptor status bits: bit15 empty, bit13 wrap, bit1 overlong, bit0 error.

## Requirements
- R1: After reset, the registers at 0x00 to 0x05 read 0, `irq` is 0 and `bufWrEn` is 0.
- R2: Each beat of an accepted frame is written once through the buffer-write port. The address is the descriptor's buffer pointer plus the byte offset within the frame. Bytes are written in arrival order.
- R3: At the last beat, the engine writes the descriptor length as the number of beats. This count includes the 4-byte check sequence, so the payload length is length minus 4. The status written back has bit15 (empty) clear and bit13 (wrap) kept as it was, and the engine sets event bit0.
- R4: If `sErr` is high on any beat of a frame, status bit0 is set. The frame is still stored and returned to software.
- R5: If a frame has more than MAX_FRAME beats, status bit1 is set. All of its bytes are still written.
- R6: After a frame, the current index moves to the next descriptor. After a descriptor with bit13 (wrap) set, the index becomes the ring base. After the last descriptor without wrap, the index becomes 0.
- R7: A frame may start while bit15 (empty) of the current descriptor is clear. The engine then sets event bit1 (busy) and receive status bit0 (halt). It increments the drop counter and writes nothing, and the descriptor is left unchanged.
- R8: While halted, every new frame is discarded whole. The drop counter increments once per frame. No buffer or descriptor writes take place, even when the current descriptor has been re-armed.
- R9: Writing a word with bit0 set to register 0x04 clears the halt, and reception resumes at the same index. Writing 1 to an event bit clears it, and writing 0 to it leaves it unchanged.
- R10: `irq` is high exactly when some event bit is set and its mask bit is set.
- R11: Setting control bit0 from 0 to 1 loads the current index from the ring base. While bit0 is 0, frames are ignored and not counted.
- R12: A frame discarded at its first beat stays discarded through its last beat, even if the halt is cleared during the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register or descriptor write strobe |
| regAddr | input | REG_AW | Register or descriptor word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| sValid | input | 1 | Frame byte valid |
| sData | input | 8 | Frame byte |
| sLast | input | 1 | Last byte of the frame |
| sErr | input | 1 | Error reported on this byte |
| bufWrEn | output | 1 | Buffer byte write strobe |
| bufWrAddr | output | BUF_W | Buffer byte address |
| bufWrData | output | 8 | Buffer byte data |
| irq | output | 1 | Masked event interrupt |

## Verification
The ring is first walked with frames that differ in four ways: a clean multi-byte frame, a single-beat frame with an error, an overlong frame, and a frame of exactly the maximum length with an error that lands on the wrap descriptor. These separate the length and status write-back from the index advance and the wrap return. Directed sequences then do the following:

- run into a software-owned descriptor;
- send frames while halted, including one after the descriptor has been re-armed;
- clear the halt in the middle of a frame;
- re-enable with a new base and run past the last descriptor without a wrap flag.

These tell a sticky halt from a per-frame check, and modulo wrap from base wrap.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef struct packed {
    logic startFrame;
    logic storeByte;
    logic finishFrame;
    logic dropFrame;
  } rdrStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rdrStateT;

  localparam int EMPTY_BIT = 15;
  localparam int WRAP_BIT  = 13;
  localparam int OVER_BIT  = 1;
  localparam int ERR_BIT   = 0;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_BASE  = 3'd1;
  localparam logic [2:0] SEL_EVT   = 3'd2;
  localparam logic [2:0] SEL_MASK  = 3'd3;
  localparam logic [2:0] SEL_RSTAT = 3'd4;
  localparam logic [2:0] SEL_DROP  = 3'd5;

  localparam int EVT_W    = 2;
  localparam int EVT_DONE = 0;
  localparam int EVT_BUSY = 1;
endpackage

// File: rtl/rdr_ctrl.sv
module rdr_ctrl
  import rdr_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regSel,
  input  logic [31:0]      regWrData,
  input  logic             sValid,
  input  logic             sLast,
  input  logic             curEmpty,
  input  logic             curWrap,
  output rdrStrobeT        strobes,
  output logic [IDX_W-1:0] curIdx,
  output logic [IDX_W-1:0] ringBase,
  output logic             enable,
  output logic             halted,
  output logic             inFrame,
  output logic [EVT_W-1:0] events,
  output logic [EVT_W-1:0] mask,
  output logic             irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  rdrStateT state, nextState;
  logic setBusy, advance;

  always_comb begin
    strobes   = '0;
    nextState = state;
    setBusy   = 1'b0;
    advance   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sValid) begin
          if (!enable) begin
            if (!sLast) nextState = ST_DROP;
          end else if (halted) begin
            strobes.dropFrame = 1'b1;
            if (!sLast) nextState = ST_DROP;
          end else if (!curEmpty) begin
            strobes.dropFrame = 1'b1;
            setBusy = 1'b1;
            if (!sLast) nextState = ST_DROP;
          end else begin
            strobes.startFrame = 1'b1;
            strobes.storeByte  = 1'b1;
            if (sLast) begin
              strobes.finishFrame = 1'b1;
              advance = 1'b1;
            end else begin
              nextState = ST_RECV;
            end
          end
        end
      end
      ST_RECV: begin
        if (sValid) begin
          strobes.storeByte = 1'b1;
          if (sLast) begin
            strobes.finishFrame = 1'b1;
            advance = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_DROP: begin
        if (sValid && sLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curIdx   <= '0;
      ringBase <= '0;
      enable   <= 1'b0;
      halted   <= 1'b0;
      events   <= '0;
      mask     <= '0;
    end else begin
      state <= nextState;
      if (advance) begin
        if (curWrap)                curIdx <= ringBase;
        else if (curIdx == LAST_IDX) curIdx <= '0;
        else                        curIdx <= curIdx + 1'b1;
      end
      if (regWr) begin
        case (regSel)
          SEL_CTRL: begin
            enable <= regWrData[0];
            if (regWrData[0] && !enable) curIdx <= ringBase;
          end
          SEL_BASE:  ringBase <= regWrData[IDX_W-1:0];
          SEL_EVT:   events <= events & ~regWrData[EVT_W-1:0];
          SEL_MASK:  mask <= regWrData[EVT_W-1:0];
          SEL_RSTAT: if (regWrData[0]) halted <= 1'b0;
          default: ;
        endcase
      end
      if (setBusy) begin
        halted <= 1'b1;
        events[EVT_BUSY] <= 1'b1;
      end
      if (strobes.finishFrame) events[EVT_DONE] <= 1'b1;
    end
  end

  assign inFrame = (state == ST_RECV);
  assign irq     = |(events & mask);
endmodule

// File: rtl/rdr_datapath.sv
module rdr_datapath
  import rdr_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int IDX_W     = $clog2(NUM_DESC),
  parameter int BUF_W     = 16,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 8,
  parameter int MAX_FRAME = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdrStrobeT        strobes,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [7:0]       sData,
  input  logic             sErr,
  input  logic             swWr,
  input  logic [IDX_W-1:0] swIdx,
  input  logic [1:0]       swField,
  input  logic [31:0]      swData,
  output logic             curEmpty,
  output logic             curWrap,
  output logic [15:0]      rdStatus,
  output logic [LEN_W-1:0] rdLen,
  output logic [BUF_W-1:0] rdPtr,
  output logic             bufWrEn,
  output logic [BUF_W-1:0] bufWrAddr,
  output logic [7:0]       bufWrData,
  output logic [CNT_W-1:0] dropCnt
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_FRAME);

  logic [15:0]      descStatus [NUM_DESC];
  logic [LEN_W-1:0] descLen    [NUM_DESC];
  logic [BUF_W-1:0] descPtr    [NUM_DESC];

  logic [LEN_W-1:0] byteCnt, offset, frameLen;
  logic             errAcc, errNow, overNow;
  logic [15:0]      newStatus;

  assign offset   = strobes.startFrame ? '0 : byteCnt;
  assign frameLen = offset + 1'b1;
  assign errNow   = (strobes.startFrame ? 1'b0 : errAcc) | sErr;
  assign overNow  = frameLen > MAX_LEN;
  assign curEmpty = descStatus[curIdx][EMPTY_BIT];
  assign curWrap  = descStatus[curIdx][WRAP_BIT];

  always_comb begin
    newStatus = '0;
    newStatus[WRAP_BIT] = curWrap;
    newStatus[OVER_BIT] = overNow;
    newStatus[ERR_BIT]  = errNow;
  end

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    logic [15:0]      stReg;
    logic [LEN_W-1:0] lenReg;
    logic [BUF_W-1:0] ptrReg;
    logic             hwHere, swHere;
    assign hwHere = strobes.finishFrame && (curIdx == IDX_W'(i));
    assign swHere = swWr && (swIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stReg  <= '0;
        lenReg <= '0;
        ptrReg <= '0;
      end else begin
        if (hwHere) begin
          stReg  <= newStatus;
          lenReg <= frameLen;
        end else if (swHere) begin
          if (swField == 2'd0) stReg  <= swData[15:0];
          if (swField == 2'd1) lenReg <= swData[LEN_W-1:0];
        end
        if (swHere && swField == 2'd2) ptrReg <= swData[BUF_W-1:0];
      end
    end
    assign descStatus[i] = stReg;
    assign descLen[i]    = lenReg;
    assign descPtr[i]    = ptrReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      errAcc    <= 1'b0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
      dropCnt   <= '0;
    end else begin
      bufWrEn <= strobes.storeByte;
      if (strobes.storeByte) begin
        byteCnt   <= frameLen;
        errAcc    <= errNow;
        bufWrAddr <= descPtr[curIdx] + BUF_W'(offset);
        bufWrData <= sData;
      end
      if (strobes.dropFrame) dropCnt <= dropCnt + 1'b1;
    end
  end

  assign rdStatus = descStatus[swIdx];
  assign rdLen    = descLen[swIdx];
  assign rdPtr    = descPtr[swIdx];
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rdr_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int BUF_W     = 16,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 8,
  parameter int MAX_FRAME = 1518,
  parameter int REG_AW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              sValid,
  input  logic [7:0]        sData,
  input  logic              sLast,
  input  logic              sErr,
  output logic              bufWrEn,
  output logic [BUF_W-1:0]  bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              irq
);
  localparam int IDX_W = $clog2(NUM_DESC);

  rdrStrobeT        strobes;
  logic [IDX_W-1:0] curIdx, ringBase, descIdx;
  logic             enable, halted, inFrame, curEmpty, curWrap, isDesc;
  logic [EVT_W-1:0] events, mask;
  logic [1:0]       descField;
  logic [2:0]       regSel;
  logic [15:0]      rdStatus;
  logic [LEN_W-1:0] rdLen;
  logic [BUF_W-1:0] rdPtr;
  logic [CNT_W-1:0] dropCnt;

  assign isDesc    = regAddr[REG_AW-1];
  assign descIdx   = regAddr[2 +: IDX_W];
  assign descField = regAddr[1:0];
  assign regSel    = regAddr[2:0];

  rdr_ctrl #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWrEn && !isDesc), .regSel(regSel),
    .regWrData(regWrData), .sValid(sValid), .sLast(sLast),
    .curEmpty(curEmpty), .curWrap(curWrap), .strobes(strobes),
    .curIdx(curIdx), .ringBase(ringBase), .enable(enable), .halted(halted),
    .inFrame(inFrame), .events(events), .mask(mask), .irq(irq)
  );

  rdr_datapath #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .BUF_W(BUF_W), .LEN_W(LEN_W),
    .CNT_W(CNT_W), .MAX_FRAME(MAX_FRAME)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curIdx(curIdx),
    .sData(sData), .sErr(sErr), .swWr(regWrEn && isDesc), .swIdx(descIdx),
    .swField(descField), .swData(regWrData), .curEmpty(curEmpty),
    .curWrap(curWrap), .rdStatus(rdStatus), .rdLen(rdLen), .rdPtr(rdPtr),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .dropCnt(dropCnt)
  );

  always_comb begin
    regRdData = '0;
    if (isDesc) begin
      case (descField)
        2'd0:    regRdData = 32'(rdStatus);
        2'd1:    regRdData = 32'(rdLen);
        2'd2:    regRdData = 32'(rdPtr);
        default: regRdData = '0;
      endcase
    end else begin
      case (regSel)
        SEL_CTRL:  regRdData = {31'd0, enable};
        SEL_BASE:  regRdData = 32'(ringBase);
        SEL_EVT:   regRdData = 32'(events);
        SEL_MASK:  regRdData = 32'(mask);
        SEL_RSTAT: regRdData = (32'(curIdx) << 8) | {31'd0, halted};
        SEL_DROP:  regRdData = 32'(dropCnt);
        default:   regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_engine_checker.sv
module rx_ring_engine_checker
  import rdr_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = $clog2(NUM_DESC)
) (
  input logic             clk,
  input logic             rstN,
  input rdrStrobeT        strobes,
  input logic             curEmpty,
  input logic [IDX_W-1:0] curIdx,
  input logic             halted,
  input logic             inFrame,
  input logic [EVT_W-1:0] events,
  input logic [EVT_W-1:0] mask,
  input logic             irq,
  input logic             bufWrEn
);
  AST_NO_STORE_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !inFrame) |=> !bufWrEn); // R8
  AST_START_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startFrame |-> curEmpty); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    32'(curIdx) < NUM_DESC); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '0) |-> !irq); // R10
  AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finishFrame |=> events[EVT_DONE]); // R3
endmodule

bind rx_ring_engine rx_ring_engine_checker #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .curEmpty(curEmpty),
  .curIdx(curIdx), .halted(halted), .inFrame(inFrame), .events(events),
  .mask(mask), .irq(irq), .bufWrEn(bufWrEn)
);

// File: tb/rx_ring_engine_test.sv
`timescale 1ns/1ps
module rx_ring_engine_test;
  localparam int ND = 4;
  localparam int MAXF = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic sValid = 1'b0, sLast = 1'b0, sErr = 1'b0;
  logic [7:0] sData = '0;
  logic bufWrEn, irq;
  logic [15:0] bufWrAddr;
  logic [7:0] bufWrData;

  int checks = 0, failures = 0, wrCount = 0;
  bit finished = 1'b0;
  logic [7:0] mem [65536];

  always #4 clk = ~clk;

  rx_ring_engine #(.NUM_DESC(ND), .MAX_FRAME(MAXF)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sValid(sValid),
    .sData(sData), .sLast(sLast), .sErr(sErr), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .irq(irq)
  );

  always @(posedge clk) if (bufWrEn) begin
    mem[bufWrAddr] <= bufWrData;
    wrCount <= wrCount + 1;
  end

  typedef struct packed {
    logic [7:0]  len;
    logic [7:0]  errBeat;
    logic [15:0] expStatus;
    logic [7:0]  expIdx;
  } vecT;
  localparam vecT [0:3] VECS = '{
    '{8'd5, 8'hFF, 16'h0000, 8'd1},
    '{8'd1, 8'd0,  16'h0001, 8'd2},
    '{8'd8, 8'hFF, 16'h0002, 8'd3},
    '{8'd6, 8'd3,  16'h2001, 8'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [7:0] dAddr(int idx, int f);
    return 8'h80 | 8'(idx << 2) | 8'(f);
  endfunction

  function automatic logic [7:0] pat(int k, int b);
    return {4'(k), 4'(b)};
  endfunction

  task automatic sendFrame(int k, int len, int errBeat);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      sValid = 1'b1; sData = pat(k, b);
      sLast = (b == len - 1); sErr = (b == errBeat);
    end
    @(negedge clk);
    sValid = 1'b0; sLast = 1'b0; sErr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      regRead(8'(a), rd);
      check("R1 reg after reset", rd, 0);
    end
    check("R1 irq after reset", {31'd0, irq}, 0);
    check("R1 bufWrEn after reset", {31'd0, bufWrEn}, 0);

    for (int i = 0; i < ND; i++) begin
      regWrite(dAddr(i, 2), 32'h1000 + i * 32'h100);
      regWrite(dAddr(i, 0), (i == ND - 1) ? 32'hA000 : 32'h8000);
    end
    regWrite(8'h01, 0);
    regWrite(8'h00, 1);

    // Table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < 4; k++) begin
      w0 = wrCount;
      sendFrame(k, VECS[k].len, VECS[k].errBeat);
      regRead(dAddr(k, 0), rd);
      check("R3 R4 R5 status", rd, 32'(VECS[k].expStatus));
      regRead(dAddr(k, 1), rd);
      check("R3 length incl FCS", rd, 32'(VECS[k].len));
      regRead(8'h04, rd);
      check("R6 index after frame", rd >> 8, 32'(VECS[k].expIdx));
      check("R2 R5 write count", wrCount - w0, 32'(VECS[k].len));
      for (int b = 0; b < VECS[k].len; b++)
        check("R2 buffer byte", 32'(mem[16'h1000 + 16'(k * 256 + b)]), 32'(pat(k, b)));
    end

    // R10 / R9 events and mask
    regRead(8'h02, rd);
    check("R3 done event", rd, 1);
    check("R10 irq masked off", {31'd0, irq}, 0);
    regWrite(8'h03, 1);
    check("R10 irq enabled", {31'd0, irq}, 1);
    regWrite(8'h02, 0);
    regRead(8'h02, rd);
    check("R9 write 0 keeps event", rd, 1);
    regWrite(8'h02, 1);
    check("R10 irq after clear", {31'd0, irq}, 0);
    regRead(8'h02, rd);
    check("R9 write 1 clears event", rd, 0);

    // R7 busy: descriptor 0 is software-owned
    w0 = wrCount;
    sendFrame(4, 3, -1);
    regRead(8'h02, rd);
    check("R7 busy event", rd, 2);
    regRead(8'h04, rd);
    check("R7 halt and index", rd, 32'h0001);
    regRead(8'h05, rd);
    check("R7 drop count", rd, 1);
    regRead(dAddr(0, 1), rd);
    check("R7 descriptor untouched", rd, 5);
    check("R7 no writes", wrCount - w0, 0);

    // R8 halted drops
    sendFrame(5, 2, -1);
    regWrite(dAddr(0, 0), 32'h8000);
    sendFrame(6, 2, -1);
    regRead(8'h05, rd);
    check("R8 drop count while halted", rd, 3);
    regRead(dAddr(0, 0), rd);
    check("R8 re-armed descriptor unchanged", rd, 32'h8000);
    check("R8 no writes while halted", wrCount - w0, 0);

    // R9 resume
    regWrite(8'h04, 1);
    regWrite(8'h02, 2);
    regRead(8'h02, rd);
    check("R9 busy cleared", rd, 0);
    sendFrame(7, 2, -1);
    regRead(dAddr(0, 1), rd);
    check("R9 resumed length", rd, 2);
    regRead(8'h04, rd);
    check("R9 resumed index, no halt", rd, 32'h0100);

    // R12 halt cleared mid-frame
    w0 = wrCount;
    @(negedge clk);
    sValid = 1'b1; sData = 8'hEE; sLast = 1'b0;
    @(negedge clk);
    sValid = 1'b0;
    regWrEn = 1'b1; regAddr = 8'h04; regWrData = 1;
    @(negedge clk);
    regAddr = dAddr(1, 0); regWrData = 32'h8000;
    @(negedge clk);
    regWrEn = 1'b0;
    sValid = 1'b1; sData = 8'hEF;
    @(negedge clk);
    sLast = 1'b1;
    @(negedge clk);
    sValid = 1'b0; sLast = 1'b0;
    @(negedge clk);
    check("R12 no writes after mid-frame clear", wrCount - w0, 0);
    regRead(8'h05, rd);
    check("R12 drop count", rd, 4);
    regRead(dAddr(1, 0), rd);
    check("R12 descriptor still empty", rd, 32'h8000);
    sendFrame(8, 3, -1);
    regRead(dAddr(1, 1), rd);
    check("R12 next frame accepted", rd, 3);

    // R11 disable, base reload; R6 modulo wrap without flag
    regWrite(8'h00, 0);
    w0 = wrCount;
    sendFrame(9, 2, -1);
    regRead(8'h05, rd);
    check("R11 disabled frame not counted", rd, 4);
    check("R11 disabled frame not written", wrCount - w0, 0);
    regWrite(8'h01, 2);
    regWrite(dAddr(2, 0), 32'h8000);
    regWrite(dAddr(3, 0), 32'h8000);
    regWrite(8'h00, 1);
    regRead(8'h04, rd);
    check("R11 index loaded from base", rd >> 8, 2);
    sendFrame(10, 2, -1);
    sendFrame(11, 4, -1);
    regRead(dAddr(3, 0), rd);
    check("R3 status without wrap", rd, 0);
    regRead(8'h04, rd);
    check("R6 modulo wrap to 0", rd >> 8, 0);
    check("R2 byte in desc 3", 32'(mem[16'h1303]), 32'(pat(11, 3)));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule